// File: doc/BRIEF.md
# Three-Phase Driver Fault Supervisor

This block supervises a three-phase gate driver. It takes a digitised overcurrent comparator output, two low-side supply comparator flags (one saying the supply is under the falling threshold, one saying it is over the rising threshold) and a global enable. From these it produces a registered shutdown signal that the phase logic uses to force all six gate outputs off. It also produces a pull-down enable for an active-low, open-drain fault line. When `fault_pull` is low the line is released and is never driven high.

An overcurrent must stay present for a filter window before it counts as a trip. A recognised trip sets a set-dominant fault latch. The latch cannot clear while the trip persists. Once the trip ends, a clear-delay counter runs for a number of cycles given by a configuration input, and the latch releases when that count runs out. Supply undervoltage is a separate fault with hysteresis and is not latched. Driving enable low shuts the outputs down but does not raise the fault line.

Top module: `drv_fault_supervisor`

## Requirements
- R1: During and after reset, `shutdown` and `fault_pull` read 1, and the supply is taken as under-voltage until `uv_above_rise` is seen high.
- R2: A trip is recognised only after `trip_raw` is 1 on FILT_CYCLES consecutive clock edges. A shorter pulse leaves both outputs unchanged.
- R3: Let `trip_raw` be first sampled 1 at edge k and stay 1. Then `shutdown` and `fault_pull` are 1 after edge k+FILT_CYCLES.
- R4: While the recognised trip persists, the fault stays latched whatever the value of `clr_delay`, and the clear timer does not advance.
- R5: Let f be the first edge at which `trip_raw` is sampled 0 after a recognised trip, and let D be `clr_delay`. With no other fault source, `fault_pull` falls after edge f+D+2. A new trip during the wait restarts the timer from zero.
- R6: The supply state enters under-voltage on an edge that sees `uv_below_fall`=1. It leaves on an edge that sees `uv_above_rise`=1 and `uv_below_fall`=0. When both flags are 0 it keeps its state.
- R7: Undervoltage is not latched. One edge after the supply state returns to normal, `fault_pull` and `shutdown` fall, provided no other source is active.
- R8: When `enable` is 0, `shutdown` is 1 after the next edge and `fault_pull` is not affected by `enable`.
- R9: `fault_pull` is 1 only when `shutdown` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trip_raw | input | 1 | Digitised overcurrent comparator output, 1 = over threshold |
| uv_below_fall | input | 1 | 1 = supply below the falling undervoltage threshold |
| uv_above_rise | input | 1 | 1 = supply above the rising undervoltage threshold |
| enable | input | 1 | Global enable, 0 forces shutdown without a fault |
| clr_delay | input | CLR_W | Clear delay in clock cycles after the trip ends |
| shutdown | output | 1 | Registered: 1 forces all six gate outputs off |
| fault_pull | output | 1 | Registered: 1 pulls the open-drain fault line low |

## Verification
The bench applies overcurrent pulses one cycle shorter than the filter window. A filter that counts an edge too few would raise the fault on these. It applies trips that are held while `clr_delay` changes, which exposes a latch that is not set-dominant or a timer that runs during the trip. It retriggers a trip part-way through the clear wait, where a design that keeps the old count would release early. It also uses a zero clear delay and holds the supply in the hysteresis band with both flags low. Enable is dropped together with a trip and with undervoltage, which catches a design that lets enable raise or mask the fault line.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;

  typedef enum logic {
    SUP_OK  = 1'b0,
    SUP_LOW = 1'b1
  } sup_state_t;

  // True once a run of consecutive high samples reaches the filter length
  function automatic logic run_complete(input int unsigned run, input int unsigned need);
    return (run + 1) >= need;
  endfunction

  // True once the quiet time after a trip has reached the programmed delay
  function automatic logic hold_elapsed(input int unsigned waited, input int unsigned limit);
    return waited >= limit;
  endfunction

endpackage

// File: rtl/trip_filter.sv
module trip_filter #(
  parameter int FILT_CYCLES = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_raw,
  output logic trip_q
);
  import drv_fault_pkg::*;

  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [CW-1:0] run_q;
  logic          run_done;

  assign run_done = run_complete(32'(run_q), 32'(FILT_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      trip_q <= 1'b0;
    end else if (!trip_raw) begin
      run_q  <= '0;
      trip_q <= 1'b0;
    end else if (run_done) begin
      trip_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_FILT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(trip_raw)); // R2

  AST_FILT_DROPS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_raw |=> !trip_q); // R2

endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int CLR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_q,
  input  logic [CLR_W-1:0] clr_delay,
  output logic             oc_q
);
  import drv_fault_pkg::*;

  logic [CLR_W-1:0] wait_q;
  logic             wait_done;

  assign wait_done = hold_elapsed(32'(wait_q), 32'(clr_delay));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q   <= 1'b0;
      wait_q <= '0;
    end else if (trip_q) begin
      oc_q   <= 1'b1;
      wait_q <= '0;
    end else if (oc_q) begin
      if (wait_done) begin
        oc_q   <= 1'b0;
        wait_q <= '0;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

  AST_OC_SET_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> oc_q); // R4

  AST_OC_TIMER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> (wait_q == '0)); // R4

  AST_OC_CLEAR_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_q) |-> ($past(wait_q) >= $past(clr_delay))); // R5

endmodule

// File: rtl/uv_hysteresis.sv
module uv_hysteresis (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_below_fall,
  input  logic uv_above_rise,
  output logic uv_low
);
  import drv_fault_pkg::*;

  sup_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SUP_OK:  if (uv_below_fall) st_d = SUP_LOW;
      SUP_LOW: if (uv_above_rise && !uv_below_fall) st_d = SUP_OK;
      default: st_d = SUP_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SUP_LOW;
    else        st_q <= st_d;
  end

  assign uv_low = (st_q == SUP_LOW);

  AST_UV_STAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_low && !uv_below_fall) |=> !uv_low); // R6

  AST_UV_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_low && !uv_above_rise) |=> uv_low); // R6

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
  parameter int FILT_CYCLES = 52,
  parameter int CLR_W       = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_raw,
  input  logic             uv_below_fall,
  input  logic             uv_above_rise,
  input  logic             enable,
  input  logic [CLR_W-1:0] clr_delay,
  output logic             shutdown,
  output logic             fault_pull
);

  logic trip_q;
  logic oc_q;
  logic uv_low;
  logic fault_any;

  trip_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw), .trip_q(trip_q)
  );

  oc_fault_latch #(.CLR_W(CLR_W)) u_oc (
    .clk(clk), .rst_n(rst_n), .trip_q(trip_q), .clr_delay(clr_delay), .oc_q(oc_q)
  );

  uv_hysteresis u_uv (
    .clk(clk), .rst_n(rst_n), .uv_below_fall(uv_below_fall),
    .uv_above_rise(uv_above_rise), .uv_low(uv_low)
  );

  assign fault_any = trip_q | oc_q | uv_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown   <= 1'b1;
      fault_pull <= 1'b1;
    end else begin
      shutdown   <= fault_any | ~enable;
      fault_pull <= fault_any;
    end
  end

  AST_FAULT_IMPLIES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pull |-> shutdown); // R9

  AST_ENABLE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> shutdown); // R8

  AST_TRIP_RAISES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> fault_pull); // R3

  AST_UV_RAISES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    uv_low |=> fault_pull); // R7

endmodule

// File: tb/drv_fault_supervisor_bench.sv
`timescale 1ns/1ps
module drv_fault_supervisor_bench;

  localparam int FILT = 52;
  localparam int CW   = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trip_raw = 1'b0;
  logic          uv_below_fall = 1'b0;
  logic          uv_above_rise = 1'b0;
  logic          enable = 1'b1;
  logic [CW-1:0] clr_delay = 20'd12;
  logic          shutdown, fault_pull;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  drv_fault_supervisor #(.FILT_CYCLES(FILT), .CLR_W(CW)) u_drv_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw), .uv_below_fall(uv_below_fall),
    .uv_above_rise(uv_above_rise), .enable(enable), .clr_delay(clr_delay),
    .shutdown(shutdown), .fault_pull(fault_pull)
  );

  // Behavioural reference: run lengths and quiet times as plain integers
  int high_run, quiet, m_sd, m_fl;
  bit seen_trip, latched, under;

  always @(posedge clk) begin
    if (!rst_n) begin
      high_run = 0; quiet = 0; seen_trip = 0; latched = 0; under = 1;
      m_sd = 1; m_fl = 1;
    end else begin
      bit ftrip_old;
      ftrip_old = (high_run >= FILT);
      m_fl = (ftrip_old || latched || under) ? 1 : 0;
      m_sd = (m_fl == 1 || !enable) ? 1 : 0;
      if (ftrip_old) begin
        latched = 1; quiet = 0;
      end else if (latched) begin
        if (quiet >= int'(clr_delay)) begin latched = 0; quiet = 0; end
        else quiet = quiet + 1;
      end
      high_run = trip_raw ? high_run + 1 : 0;
      if (under) begin
        if (uv_above_rise && !uv_below_fall) under = 0;
      end else if (uv_below_fall) under = 1;
    end
  end

  task automatic chk(input string what, input logic act, input int expv);
    total++;
    if (act !== expv[0]) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0d", cur_req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("shutdown", shutdown, m_sd);
      chk("fault_pull", fault_pull, m_fl);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trip_pulse(input int n);
    @(negedge clk); trip_raw = 1'b1;
    idle(n);
    trip_raw = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(5);
    rst_n = 1'b1;
    idle(6);
    chk("R1 reset fault held", fault_pull, 1);

    cur_req = "R7";
    uv_above_rise = 1'b1; idle(1); uv_above_rise = 1'b0;
    idle(6);
    chk("R7 released after supply ok", fault_pull, 0);

    cur_req = "R2";
    trip_pulse(FILT - 1);
    idle(10);
    chk("R2 short pulse ignored", fault_pull, 0);
    trip_pulse(FILT - 1);
    idle(3);

    cur_req = "R3";
    @(negedge clk); trip_raw = 1'b1;
    idle(FILT + 2);
    chk("R3 trip raises fault", fault_pull, 1);
    cur_req = "R4";
    clr_delay = 20'd0;
    idle(20);
    clr_delay = 20'd12;
    idle(20);
    chk("R4 held during trip", fault_pull, 1);
    cur_req = "R5";
    trip_raw = 1'b0;
    idle(30);
    chk("R5 released after delay", fault_pull, 0);

    clr_delay = 20'd0;
    trip_pulse(60);
    idle(10);
    clr_delay = 20'd40;
    trip_pulse(60);
    idle(20);
    trip_pulse(60);
    idle(30);
    chk("R5 retrigger restarts wait", fault_pull, 1);
    idle(30);

    cur_req = "R6";
    uv_below_fall = 1'b1; idle(2); uv_below_fall = 1'b0;
    idle(10);
    chk("R6 stays under in band", fault_pull, 1);
    uv_above_rise = 1'b1; uv_below_fall = 1'b1; idle(3);
    uv_below_fall = 1'b0;
    cur_req = "R7";
    idle(2); uv_above_rise = 1'b0;
    idle(5);

    cur_req = "R8";
    enable = 1'b0; idle(10);
    chk("R8 enable low no fault", fault_pull, 0);
    chk("R8 enable low shutdown", shutdown, 1);
    clr_delay = 20'd5;
    trip_pulse(60);
    idle(20);
    enable = 1'b1; idle(10);

    cur_req = "R9";
    enable = 1'b0; uv_below_fall = 1'b1; idle(4); uv_below_fall = 1'b0;
    trip_pulse(55);
    uv_above_rise = 1'b1; idle(3); uv_above_rise = 1'b0;
    enable = 1'b1; idle(20);
    trip_pulse(53);
    enable = 1'b0; idle(3); enable = 1'b1;
    idle(20);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule